// File: doc/BRIEF.md
# Four-Sided Programmable Switch Matrix

This block is a routing switch box that sits at the corners of logic tiles. It joins four routing channels (north, east, south and west), each eight wires wide, through 48 programmable bidirectional connections. Each connection is opened or closed by one configuration bit. The whole configuration is captured at once, as a single context word, when a load strobe is asserted.

Each wire terminal on each side is modelled as three signals: an input value, a flag that says the terminal is being driven from outside, and an output with its output enable. There are no internal tri-state nets. For every wire index, a resolver works out which terminals are joined through closed switches, including paths through more than one switch. It then drives each undriven terminal that is connected to an externally driven terminal. It raises a per-index conflict flag when the drivers on one connected net disagree.

Top module: `switch_matrix4`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the context is cleared, whatever the load strobe and data are. After reset, every output enable and every conflict bit is 0.
- R2: When `cfg_load` is high at a rising edge, all 48 bits of `cfg_in` are captured together. The new context governs the outputs from just after that edge. While `cfg_load` is low, changes on `cfg_in` have no effect.
- R3: Context bit `6*i + p` closes switch `p` for wire index `i`. The switches, numbered from 0, join the side pairs in this order: N-E, N-S, N-W, E-S, E-W, S-W.
- R4: A terminal asserts its output enable only if two conditions hold: it is not driven externally, and it is joined through closed switches to at least one externally driven terminal.
- R5: Connections are transitive. A terminal reached through a chain of closed switches is driven with the value of the net, which is the value of the external driver.
- R6: A terminal whose drive flag is set never has its output enable asserted.
- R7: `conflict[i]` is 1 when two externally driven terminals on one connected net of wire index `i` carry different values. The net value is then the logical OR of its drivers.
- R8: Wire indices are independent. Switches and drivers at index `i` never affect terminals at any other index.
- R9: Each switch conducts in both directions. The same closed switch carries a value from either of its two sides to the other.
- R10: A net with no externally driven terminal drives nothing. With an all-zero context, no output enable is ever asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Captures `cfg_in` as the new context |
| cfg_in | input | 48 | Parallel context word, one bit per switch |
| n_in | input | 8 | North terminal input values |
| n_drv | input | 8 | North terminals driven externally |
| n_out | output | 8 | North terminal output values |
| n_oe | output | 8 | North terminal output enables |
| e_in | input | 8 | East terminal input values |
| e_drv | input | 8 | East terminals driven externally |
| e_out | output | 8 | East terminal output values |
| e_oe | output | 8 | East terminal output enables |
| s_in | input | 8 | South terminal input values |
| s_drv | input | 8 | South terminals driven externally |
| s_out | output | 8 | South terminal output values |
| s_oe | output | 8 | South terminal output enables |
| w_in | input | 8 | West terminal input values |
| w_drv | input | 8 | West terminals driven externally |
| w_out | output | 8 | West terminal output values |
| w_oe | output | 8 | West terminal output enables |
| conflict | output | 8 | Per wire index, drivers on one net disagree |

## Verification
The bench closes each of the six switches of one wire index alone and confirms that only the partner side responds. A design with a swapped pair order, or with the wrong stride in the bit index, would enable the wrong side. It routes values through two-switch chains: a resolver that looks only at direct neighbours would leave the far terminal undriven. It drives from both ends of one switch: a one-way switch would stay silent in the reverse direction. It pits disagreeing drivers against agreeing ones on one net: a missing or always-set conflict flag, or a driver echoing back onto its own terminal, shows up directly at the ports. Changes on the context input without the strobe, and a full context with no driver present, catch a context register that follows its input and an output enable raised with no source.

// File: rtl/swm_pkg.sv
// Package: shared constants and the switch-to-side-pair mapping.
// Assumes sides are numbered N=0, E=1, S=2, W=3.
package swm_pkg;
    localparam int unsigned NUM_SIDES = 4;
    localparam int unsigned NUM_PAIRS = NUM_SIDES * (NUM_SIDES - 1) / 2;

    typedef enum logic [1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

    // Lower-numbered side of switch p (order N-E, N-S, N-W, E-S, E-W, S-W).
    function automatic int unsigned pair_lo(input int unsigned p);
        case (p)
            0, 1, 2: pair_lo = 0;
            3, 4:    pair_lo = 1;
            default: pair_lo = 2;
        endcase
    endfunction

    // Higher-numbered side of switch p.
    function automatic int unsigned pair_hi(input int unsigned p);
        case (p)
            0:       pair_hi = 1;
            1, 3:    pair_hi = 2;
            default: pair_hi = 3;
        endcase
    endfunction
endpackage

// File: rtl/swm_ctx_reg.sv
// Context register: holds the switch configuration word.
// Loads the whole word at once on cfg_load. Synchronous active-low reset clears it.
module swm_ctx_reg #(
    parameter int unsigned CTX_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CTX_W-1:0] d,
    output logic [CTX_W-1:0] q
);
    // Capture the context on load; reset has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R1: reset empties the context.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R2: a load captures the word presented at the strobe edge.
    p_load_captures_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R2: without a load the context holds.
    p_hold_without_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/swm_net_closure.sv
// Net closure: turns the closed switches of one wire index into a
// reachability matrix over the four sides. Purely combinational.
// reach[a*NUM_SIDES+b] is 1 when side a and side b share a net.
// The diagonal is always 1.
module swm_net_closure
    import swm_pkg::*;
(
    input  logic [NUM_PAIRS-1:0]           link,
    output logic [NUM_SIDES*NUM_SIDES-1:0] reach
);
    // Build the adjacency from the switches, then apply a Warshall closure.
    always_comb begin
        logic [NUM_SIDES-1:0] r [NUM_SIDES];
        for (int a = 0; a < NUM_SIDES; a++) begin
            r[a] = '0;
            r[a][a] = 1'b1;
        end
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (link[p]) begin
                r[pair_lo(p)][pair_hi(p)] = 1'b1;
                r[pair_hi(p)][pair_lo(p)] = 1'b1;
            end
        end
        for (int k = 0; k < NUM_SIDES; k++)
            for (int a = 0; a < NUM_SIDES; a++)
                for (int b = 0; b < NUM_SIDES; b++)
                    r[a][b] = r[a][b] | (r[a][k] & r[k][b]);
        for (int a = 0; a < NUM_SIDES; a++)
            for (int b = 0; b < NUM_SIDES; b++)
                reach[a*NUM_SIDES+b] = r[a][b];
    end
endmodule

// File: rtl/swm_resolver.sv
// Direction resolver for one wire index.
// Given the reachability matrix and the terminal drive flags, it drives each
// undriven terminal that shares a net with a driver, using the net value
// (the OR of the drivers). It flags disagreeing drivers on a shared net.
module swm_resolver
    import swm_pkg::*;
(
    input  logic [NUM_SIDES*NUM_SIDES-1:0] reach,
    input  logic [NUM_SIDES-1:0]           t_in,
    input  logic [NUM_SIDES-1:0]           t_drv,
    output logic [NUM_SIDES-1:0]           t_out,
    output logic [NUM_SIDES-1:0]           t_oe,
    output logic                           conflict
);
    // Net value and source presence for each terminal.
    always_comb begin
        for (int k = 0; k < NUM_SIDES; k++) begin
            logic val;
            logic src;
            val = 1'b0;
            src = 1'b0;
            for (int j = 0; j < NUM_SIDES; j++) begin
                val = val | (reach[k*NUM_SIDES+j] & t_drv[j] & t_in[j]);
                src = src | (reach[k*NUM_SIDES+j] & t_drv[j]);
            end
            t_out[k] = val;
            t_oe[k]  = src & ~t_drv[k];
        end
    end

    // Conflict: two connected drivers with different values.
    always_comb begin
        conflict = 1'b0;
        for (int j = 0; j < NUM_SIDES; j++)
            for (int k = j + 1; k < NUM_SIDES; k++)
                conflict = conflict | (reach[j*NUM_SIDES+k] & t_drv[j] &
                                       t_drv[k] & (t_in[j] ^ t_in[k]));
    end
endmodule

// File: rtl/switch_matrix4.sv
// Four-sided programmable switch matrix.
// Holds a 6*WIRES-bit context. For each wire index it builds the nets and
// resolves drive directions. Context bit 6*i+p closes switch p of index i.
// Assumes the drive flags tell which terminals are driven from outside.
module switch_matrix4
    import swm_pkg::*;
#(
    parameter int unsigned WIRES = 8,
    localparam int unsigned CTX_W = WIRES * NUM_PAIRS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [CTX_W-1:0] cfg_in,
    input  logic [WIRES-1:0] n_in,
    input  logic [WIRES-1:0] n_drv,
    output logic [WIRES-1:0] n_out,
    output logic [WIRES-1:0] n_oe,
    input  logic [WIRES-1:0] e_in,
    input  logic [WIRES-1:0] e_drv,
    output logic [WIRES-1:0] e_out,
    output logic [WIRES-1:0] e_oe,
    input  logic [WIRES-1:0] s_in,
    input  logic [WIRES-1:0] s_drv,
    output logic [WIRES-1:0] s_out,
    output logic [WIRES-1:0] s_oe,
    input  logic [WIRES-1:0] w_in,
    input  logic [WIRES-1:0] w_drv,
    output logic [WIRES-1:0] w_out,
    output logic [WIRES-1:0] w_oe,
    output logic [WIRES-1:0] conflict
);
    logic [CTX_W-1:0] ctx_q;

    swm_ctx_reg #(.CTX_W(CTX_W)) i_ctx (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cfg_load),
        .d    (cfg_in),
        .q    (ctx_q)
    );

    for (genvar w = 0; w < WIRES; w++) begin : g_wire
        logic [NUM_SIDES*NUM_SIDES-1:0] reach;
        logic [NUM_SIDES-1:0]           t_in;
        logic [NUM_SIDES-1:0]           t_drv;
        logic [NUM_SIDES-1:0]           t_out;
        logic [NUM_SIDES-1:0]           t_oe;

        // Gather this index's terminals in side order N, E, S, W.
        assign t_in  = {w_in[w],  s_in[w],  e_in[w],  n_in[w]};
        assign t_drv = {w_drv[w], s_drv[w], e_drv[w], n_drv[w]};

        swm_net_closure i_closure (
            .link (ctx_q[w*NUM_PAIRS +: NUM_PAIRS]),
            .reach(reach)
        );

        swm_resolver i_resolver (
            .reach   (reach),
            .t_in    (t_in),
            .t_drv   (t_drv),
            .t_out   (t_out),
            .t_oe    (t_oe),
            .conflict(conflict[w])
        );

        // Scatter the resolved drives back onto the side ports.
        assign n_out[w] = t_out[SIDE_N];
        assign e_out[w] = t_out[SIDE_E];
        assign s_out[w] = t_out[SIDE_S];
        assign w_out[w] = t_out[SIDE_W];
        assign n_oe[w]  = t_oe[SIDE_N];
        assign e_oe[w]  = t_oe[SIDE_E];
        assign s_oe[w]  = t_oe[SIDE_S];
        assign w_oe[w]  = t_oe[SIDE_W];

        // R6: a driven terminal is never driven back.
        p_no_drive_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (t_oe & t_drv) == '0);

        // R4: any output enable needs an external source at this index.
        p_oe_needs_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (|t_oe) |-> (|t_drv));

        // R7: a conflict needs at least two drivers.
        p_conflict_two_drivers_r7: assert property (@(posedge clk) disable iff (!rst_n)
            conflict[w] |-> ($countones(t_drv) >= 2));

        // R9: the nets are symmetric, so every switch works both ways.
        p_symmetric_nets_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (reach[SIDE_N*NUM_SIDES+SIDE_S] == reach[SIDE_S*NUM_SIDES+SIDE_N]) &&
            (reach[SIDE_E*NUM_SIDES+SIDE_W] == reach[SIDE_W*NUM_SIDES+SIDE_E]));
    end

    // R10: an empty context drives nothing.
    p_empty_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q == '0) |-> ((n_oe | e_oe | s_oe | w_oe) == '0));
endmodule

// File: tb/test_switch_matrix4.sv
// Directed bench for switch_matrix4. Each task runs one scenario and checks it.
module test_switch_matrix4;
    localparam int W  = 8;
    localparam int CW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [CW-1:0] cfg_in = '0;
    logic [W-1:0]  n_in = '0, n_drv = '0, e_in = '0, e_drv = '0;
    logic [W-1:0]  s_in = '0, s_drv = '0, w_in = '0, w_drv = '0;
    logic [W-1:0]  n_out, n_oe, e_out, e_oe, s_out, s_oe, w_out, w_oe, conflict;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    switch_matrix4 i_switch_matrix4 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_in(cfg_in),
        .n_in(n_in), .n_drv(n_drv), .n_out(n_out), .n_oe(n_oe),
        .e_in(e_in), .e_drv(e_drv), .e_out(e_out), .e_oe(e_oe),
        .s_in(s_in), .s_drv(s_drv), .s_out(s_out), .s_oe(s_oe),
        .w_in(w_in), .w_drv(w_drv), .w_out(w_out), .w_oe(w_oe),
        .conflict(conflict)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_sides();
        n_in = '0; n_drv = '0; e_in = '0; e_drv = '0;
        s_in = '0; s_drv = '0; w_in = '0; w_drv = '0;
        #1;
    endtask

    // Load a context: strobe over one rising edge, sample after the next falling edge.
    task automatic load_ctx(input logic [CW-1:0] v);
        @(negedge clk);
        cfg_in = v;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        #1;
    endtask

    // Drive one terminal (side 0..3 = N,E,S,W) at index i.
    task automatic drive(input int side, input int i, input logic v);
        case (side)
            0: begin n_drv[i] = 1'b1; n_in[i] = v; end
            1: begin e_drv[i] = 1'b1; e_in[i] = v; end
            2: begin s_drv[i] = 1'b1; s_in[i] = v; end
            default: begin w_drv[i] = 1'b1; w_in[i] = v; end
        endcase
        #1;
    endtask

    function automatic logic [W-1:0] oe_of(input int side);
        case (side)
            0: oe_of = n_oe;
            1: oe_of = e_oe;
            2: oe_of = s_oe;
            default: oe_of = w_oe;
        endcase
    endfunction

    function automatic logic [W-1:0] out_of(input int side);
        case (side)
            0: out_of = n_out;
            1: out_of = e_out;
            2: out_of = s_out;
            default: out_of = w_out;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        cfg_in = '1;
        cfg_load = 1'b1;
        n_drv = '1; n_in = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cfg_load = 1'b0;
        #1;
        check("R1", "e_oe after reset", e_oe, 8'h00);
        check("R1", "s_oe|w_oe after reset", s_oe | w_oe, 8'h00);
        check("R10", "conflict after reset", conflict, 8'h00);
        clear_sides();
    endtask

    task automatic t_pair_order();
        int lo [6] = '{0, 0, 0, 1, 1, 2};
        int hi [6] = '{1, 2, 3, 2, 3, 3};
        for (int p = 0; p < 6; p++) begin
            logic [CW-1:0] c;
            c = '0;
            c[6*5 + p] = 1'b1;
            load_ctx(c);
            clear_sides();
            drive(lo[p], 5, 1'b1);
            for (int sd = 0; sd < 4; sd++)
                check("R3", $sformatf("pair %0d side %0d oe", p, sd), oe_of(sd),
                      (sd == hi[p]) ? 8'h20 : 8'h00);
            check("R5", $sformatf("pair %0d value", p), out_of(hi[p]) & 8'h20, 8'h20);
        end
        clear_sides();
    endtask

    task automatic t_bidir();
        logic [CW-1:0] c;
        c = '0;
        c[6*3 + 0] = 1'b1;
        load_ctx(c);
        clear_sides();
        drive(0, 3, 1'b1);
        check("R4", "N drives E oe", e_oe, 8'h08);
        check("R6", "driven N not driven back", n_oe, 8'h00);
        clear_sides();
        drive(1, 3, 1'b1);
        check("R9", "E drives N oe", n_oe, 8'h08);
        check("R9", "E drives N value", n_out & 8'h08, 8'h08);
        check("R6", "driven E not driven back", e_oe, 8'h00);
        clear_sides();
    endtask

    task automatic t_multihop();
        logic [CW-1:0] c;
        c = '0;
        c[0] = 1'b1;
        c[3] = 1'b1;
        load_ctx(c);
        clear_sides();
        drive(0, 0, 1'b1);
        check("R5", "chain oe on E", e_oe, 8'h01);
        check("R5", "chain oe on S", s_oe, 8'h01);
        check("R5", "chain value on S", s_out & 8'h01, 8'h01);
        check("R4", "W not on net", w_oe, 8'h00);
        clear_sides();
        drive(0, 0, 1'b0);
        check("R5", "chain value 0 on S", s_out & 8'h01, 8'h00);
        check("R5", "chain oe for 0 on S", s_oe, 8'h01);
        clear_sides();
    endtask

    task automatic t_no_driver();
        load_ctx('1);
        clear_sides();
        n_in = '1; e_in = '1;
        #1;
        check("R10", "no driver, all oe", n_oe | e_oe | s_oe | w_oe, 8'h00);
        clear_sides();
    endtask

    task automatic t_conflict();
        logic [CW-1:0] c;
        c = '0;
        c[6*2 + 1] = 1'b1;
        load_ctx(c);
        clear_sides();
        drive(0, 2, 1'b1);
        drive(2, 2, 1'b0);
        check("R7", "disagreeing drivers", conflict, 8'h04);
        check("R4", "isolated E/W quiet", e_oe | w_oe, 8'h00);
        c[6*2 + 0] = 1'b1;
        load_ctx(c);
        check("R7", "OR value on E", e_out & 8'h04, 8'h04);
        check("R7", "E enabled", e_oe, 8'h04);
        clear_sides();
        drive(0, 2, 1'b1);
        drive(2, 2, 1'b1);
        check("R7", "agreeing drivers", conflict, 8'h00);
        clear_sides();
        drive(1, 2, 1'b1);
        drive(3, 2, 1'b0);
        check("R7", "drivers on separate nets", conflict, 8'h00);
        clear_sides();
    endtask

    task automatic t_hold();
        logic [CW-1:0] c;
        c = '0;
        c[6*6 + 4] = 1'b1;
        load_ctx(c);
        clear_sides();
        drive(1, 6, 1'b1);
        @(negedge clk);
        cfg_in = '0;
        @(negedge clk);
        cfg_in = '1;
        @(negedge clk);
        #1;
        check("R2", "context held without strobe, W oe", w_oe, 8'h40);
        check("R2", "context held, N quiet", n_oe, 8'h00);
        load_ctx('0);
        check("R2", "new context after strobe", w_oe, 8'h00);
        clear_sides();
    endtask

    task automatic t_independent();
        logic [CW-1:0] c;
        c = '0;
        c[6*4 +: 6] = 6'h3f;
        load_ctx(c);
        clear_sides();
        n_drv = '1;
        n_in = 8'h10;
        #1;
        check("R8", "only index 4 on E", e_oe, 8'h10);
        check("R8", "only index 4 on W", w_oe, 8'h10);
        check("R8", "value on S", s_out & 8'h10, 8'h10);
        clear_sides();
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_pair_order();
        t_bidir();
        t_multihop();
        t_no_driver();
        t_conflict();
        t_hold();
        t_independent();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule